// File: doc/BRIEF.md
# BCD clock calendar core

This block keeps the time of day and the calendar date as packed BCD bytes: seconds, minutes, hours, day of week, date, month, two-digit year and century. A timebase pulse input (nominally 32.768 kHz, one clock-wide pulse per period) is divided down inside the block to a once-per-second advance. The carries follow the real calendar. Each month ends on its true last day. February gains a 29th day in every year whose two-digit value is a multiple of four, which is correct up to 2099. A year of 99 rolls into the century byte.

A host reaches the fields through a byte-wide parallel bus with active-low chip enable, write enable and output enable. The top sixteen addresses form the register window, and every lower address is flagged for an external memory. The host never reads the running counters directly. It reads a user-side copy that follows them while the block is idle. Setting a freeze bit pins that copy so that a multi-byte read is coherent, while the counters keep running underneath. A written field appears in the copy at once. It is committed to the counters at the next timebase pulse, which also restarts the sub-second divider. A stop bit halts the divider, and a square wave taken from the divider lets the host check the timebase.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: The window is every address whose upper AW-4 bits are all ones. `mem_sel` is high exactly when `ce_n` is low and the address is below the window. `rd_en` is high exactly when `ce_n` and `oe_n` are low, `we_n` is high and the address is in the window. `rdata` is 0 when `rd_en` is low. A write takes effect only on a clock edge where `ce_n` and `we_n` are both low and the address is in the window.
- R2: Window offsets (the low 4 address bits): 0 is control, with bit 0 = freeze and bit 1 = oscillator stop (other bits read 0). Then 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year and 8 century. Offsets 9 to 15 read 0, and writes to them are ignored.
- R3: After reset the fields read control 00, 00:00:00, day of week 01, date 01, month 01, year 00 and century 20.
- R4: Time advances by one second on every 2^PRE_BITS-th timebase pulse counted since the divider was last cleared.
- R5: Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00, each counting in BCD and carrying into the next field.
- R6: Day of week counts 1 to 7, steps together with the date at midnight, and wraps from 7 to 1.
- R7: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other months except February. February ends on 29 when the year is a multiple of four (00 included) and on 28 otherwise.
- R8: Year wraps from 99 to 00 and increments the century.
- R9: While freeze is set, reads of the time fields return the values held when freeze was set, even as seconds pass. Once freeze is cleared, the reads show the live time, with no seconds lost.
- R10: A field write is readable at once. It is loaded into the counter on the next timebase pulse, and that pulse clears the divider instead of advancing it.
- R11: While stop is set, timebase pulses do not advance the divider or the time, but pending field writes are still loaded on a pulse.
- R12: `sq512` is divider bit PRE_BITS-10 (a square wave with a period of 64 timebase pulses), and it is 0 right after a load clears the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per timebase period |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data from the register window |
| rd_en | output | 1 | Read data valid / drive enable |
| mem_sel | output | 1 | Access falls below the register window |
| sq512 | output | 1 | Divided timebase test output |

## Verification
A wrong carry in the counter chain shows in the user copy one clock after the second that crosses the boundary, because the copy refreshes on the cycle after each advance. The bench therefore starts each calendar corner one second before the boundary and reads right after it. A divider that is off by even one pulse moves a second across the 2^PRE_BITS-pulse edge, which the reads on either side of that edge expose. A pending bit that is lost or never cleared shows up on a later read as either the old field value or a value that no longer advances.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NFIELD = 8;

  // field index inside the counter vector; window offset is index + 1
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_WDAY  = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;
  localparam int F_CENT  = 7;

  localparam logic [3:0] OFF_CTRL = 4'd0;

  typedef logic [NFIELD-1:0][7:0] field_vec_t;

  // century 20, year 00, month 01, date 01, weekday 01, 00:00:00
  localparam field_vec_t FIELD_RESET =
    {8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  // one BCD step, caller handles the wrap value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of four in binary terms, valid through the 2099 horizon
  function automatic logic is_leap(input logic [7:0] y);
    logic [7:0] b;
    b = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    is_leap = ((b & 8'h03) == 8'h00);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      month_last = is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
      default:                    month_last = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int PRE_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tb_tick,
  input  logic halt,
  input  logic clear,
  output logic sec_pulse,
  output logic sq_out
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TAP = (PRE_BITS >= 10) ? PRE_BITS - 10 : 0;
  localparam logic [PRE_BITS-1:0] LAST = '1;
  localparam logic [PRE_BITS-1:0] ONE  = PRE_BITS'(1);

  logic [PRE_BITS-1:0] cnt;
  logic step;

  assign step      = tb_tick && !halt && !clear;
  assign sec_pulse = step && (cnt == LAST);
  assign sq_out    = cnt[TAP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + ONE;
  end

  // R11: a stopped divider does not move unless a load clears it
  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !clear) |=> $stable(cnt));

  // R10: a load pulse leaves the divider at zero
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0) && !sq_out);
endmodule

// File: rtl/rtc_chain.sv
module rtc_chain
  import rtc_cal_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sec_pulse,
  input  logic                load,
  input  logic [NFIELD-1:0]   load_mask,
  input  field_vec_t          load_val,
  output field_vec_t          live
);
  timeunit 1ns;
  timeprecision 1ps;

  field_vec_t f, nxt;
  logic w_sec, w_min, w_hr, w_date, w_mon, w_yr;
  logic day_roll, year_roll;

  always_comb begin
    w_sec  = (f[F_SEC] == 8'h59);
    w_min  = w_sec && (f[F_MIN] == 8'h59);
    w_hr   = w_min && (f[F_HOUR] == 8'h23);
    w_date = w_hr && (f[F_DATE] == month_last(f[F_MONTH], f[F_YEAR]));
    w_mon  = w_date && (f[F_MONTH] == 8'h12);
    w_yr   = w_mon && (f[F_YEAR] == 8'h99);

    nxt = f;
    nxt[F_SEC] = w_sec ? 8'h00 : bcd_inc(f[F_SEC]);
    if (w_sec) nxt[F_MIN]  = w_min ? 8'h00 : bcd_inc(f[F_MIN]);
    if (w_min) nxt[F_HOUR] = w_hr ? 8'h00 : bcd_inc(f[F_HOUR]);
    if (w_hr) begin
      nxt[F_WDAY] = (f[F_WDAY] == 8'h07) ? 8'h01 : bcd_inc(f[F_WDAY]);
      nxt[F_DATE] = w_date ? 8'h01 : bcd_inc(f[F_DATE]);
    end
    if (w_date) nxt[F_MONTH] = w_mon ? 8'h01 : bcd_inc(f[F_MONTH]);
    if (w_mon)  nxt[F_YEAR]  = w_yr ? 8'h00 : bcd_inc(f[F_YEAR]);
    if (w_yr)   nxt[F_CENT]  = (f[F_CENT] == 8'h99) ? 8'h00 : bcd_inc(f[F_CENT]);
  end

  assign day_roll  = sec_pulse && w_hr;
  assign year_roll = sec_pulse && w_yr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f <= FIELD_RESET;
    end else if (load) begin
      for (int i = 0; i < NFIELD; i++)
        if (load_mask[i]) f[i] <= load_val[i];
    end else if (sec_pulse) begin
      f <= nxt;
    end
  end

  assign live = f;

  // R4: no pulse and no load means the time stands still
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !load) |=> $stable(f));

  // R5: seconds at 59 come back to 00 on the next advance
  p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !load && f[F_SEC] == 8'h59) |=> (f[F_SEC] == 8'h00));

  // R6: weekday 7 is followed by weekday 1
  p_wday_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (day_roll && !load && f[F_WDAY] == 8'h07) |=> (f[F_WDAY] == 8'h01));

  // R7: the 28th of February in a common year goes to the 1st of March
  p_feb_common_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (day_roll && !load && f[F_MONTH] == 8'h02 && f[F_DATE] == 8'h28 && !is_leap(f[F_YEAR]))
    |=> (f[F_DATE] == 8'h01 && f[F_MONTH] == 8'h03));

  // R8: the end of year 99 moves the century on
  p_cent_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (year_roll && !load) |=> (f[F_YEAR] == 8'h00 && f[F_CENT] != $past(f[F_CENT])));
endmodule

// File: rtl/rtc_regwin.sv
module rtc_regwin
  import rtc_cal_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        wdata,
  input  field_vec_t        live,
  input  logic              load_stb,
  output logic [7:0]        rdata,
  output logic              rd_en,
  output logic              mem_sel,
  output logic              freeze,
  output logic              halt,
  output field_vec_t        shadow,
  output logic [NFIELD-1:0] pend
);
  timeunit 1ns;
  timeprecision 1ps;

  logic       hit, wr, refresh;
  logic [3:0] off;
  logic [1:0] ctl;
  logic [7:0] rsel;

  assign hit     = &addr[AW-1:4];
  assign off     = addr[3:0];
  assign wr      = !ce_n && !we_n && hit;
  assign rd_en   = !ce_n && !oe_n && we_n && hit;
  assign mem_sel = !ce_n && !hit;
  assign freeze  = ctl[0];
  assign halt    = ctl[1];
  assign refresh = !freeze && (pend == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      shadow <= FIELD_RESET;
      pend   <= '0;
    end else begin
      if (wr && off == OFF_CTRL) ctl <= wdata[1:0];
      for (int i = 0; i < NFIELD; i++) begin
        if (wr && off == 4'(i + 1)) begin
          shadow[i] <= wdata;
          pend[i]   <= 1'b1;
        end else begin
          if (refresh)  shadow[i] <= live[i];
          if (load_stb) pend[i]   <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rsel = 8'h00;
    if (off == OFF_CTRL) rsel = {6'd0, ctl};
    for (int i = 0; i < NFIELD; i++)
      if (off == 4'(i + 1)) rsel = shadow[i];
  end

  assign rdata = rd_en ? rsel : 8'h00;

  // R9: a frozen copy changes only through a host write
  p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr) |=> $stable(shadow));

  // R10: a load pulse retires every pending write
  p_pend_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !wr) |=> (pend == '0));

  // R1: window reads and memory selects never coincide with an idle bus
  p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!rd_en && !mem_sel && rdata == 8'h00));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int AW       = 15,
  parameter int PRE_BITS = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_tick,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          rd_en,
  output logic          mem_sel,
  output logic          sq512
);
  timeunit 1ns;
  timeprecision 1ps;

  field_vec_t        live, shadow;
  logic [NFIELD-1:0] pend;
  logic              freeze, halt, load_stb, sec_pulse;

  // commit point for host writes: the first timebase pulse after them
  assign load_stb = osc_tick && (pend != '0);

  rtc_regwin #(.AW(AW)) u_win (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .live(live), .load_stb(load_stb),
    .rdata(rdata), .rd_en(rd_en), .mem_sel(mem_sel),
    .freeze(freeze), .halt(halt), .shadow(shadow), .pend(pend)
  );

  rtc_divider #(.PRE_BITS(PRE_BITS)) u_div (
    .clk(clk), .rst_n(rst_n), .tb_tick(osc_tick), .halt(halt),
    .clear(load_stb), .sec_pulse(sec_pulse), .sq_out(sq512)
  );

  rtc_chain u_chain (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .load(load_stb),
    .load_mask(pend), .load_val(shadow), .live(live)
  );

  // R11: a stopped oscillator yields no second advance
  p_stop_no_sec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !sec_pulse);

  // R10: a load tick never also counts a second
  p_load_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> !sec_pulse);
endmodule

// File: tb/rtc_bcd_calendar_test.sv
module rtc_bcd_calendar_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 15;
  localparam int PB = 11;
  localparam int SECOND = 1 << PB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          osc_tick = 1'b0;
  logic          ce_n = 1'b1;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          rd_en, mem_sel, sq512;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  rtc_bcd_calendar #(.AW(AW), .PRE_BITS(PB)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rd_en(rd_en),
    .mem_sel(mem_sel), .sq512(sq512)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // driver: queue the expectation, then perform the read cycle
  task automatic rd(input logic [3:0] off, input logic [7:0] e, input string req);
    exp_t it;
    it.exp = e;
    it.req = req;
    @(negedge clk);
    q.push_back(it);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    addr = {{(AW-4){1'b1}}, off};
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    addr = {{(AW-4){1'b1}}, off};
    wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      osc_tick = 1'b1;
    end
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] wd, input logic [7:0] d, input logic [7:0] mo,
                          input logic [7:0] y, input logic [7:0] c);
    wr(4'd1, s); wr(4'd2, m); wr(4'd3, h); wr(4'd4, wd);
    wr(4'd5, d); wr(4'd6, mo); wr(4'd7, y); wr(4'd8, c);
    ticks(1);
  endtask

  // monitor: compare each window read as the design presents it
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rd_en) begin
        if (q.size() == 0) begin
          check(1'b0, "R1 unexpected read strobe", rdata, 0);
        end else begin
          exp_t it;
          it = q.pop_front();
          check(rdata == it.exp, it.req, rdata, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    check(q.size() == 0, "R1 read strobe missing", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset contents, R2 offsets and empty slots
    rd(4'd0, 8'h00, "R3 control");
    rd(4'd1, 8'h00, "R3 seconds");
    rd(4'd3, 8'h00, "R3 hours");
    rd(4'd4, 8'h01, "R3 weekday");
    rd(4'd5, 8'h01, "R3 date");
    rd(4'd6, 8'h01, "R3 month");
    rd(4'd7, 8'h00, "R3 year");
    rd(4'd8, 8'h20, "R3 century");
    rd(4'd9, 8'h00, "R2 empty slot");

    // R1 decode below and inside the window
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 15'h0123;
    #1;
    check(mem_sel == 1'b1, "R1 memory select", mem_sel, 1);
    check(rd_en == 1'b0, "R1 no window read", rd_en, 0);
    @(negedge clk);
    oe_n = 1'b1; addr = {{(AW-4){1'b1}}, 4'd1};
    #1;
    check(mem_sel == 1'b0, "R1 window not memory", mem_sel, 0);
    @(negedge clk);
    ce_n = 1'b1;

    // R10 immediate visibility, R4 divider length
    wr(4'd1, 8'h58);
    rd(4'd1, 8'h58, "R10 write visible");
    ticks(1);
    ticks(SECOND - 1);
    rd(4'd1, 8'h58, "R4 one pulse short");
    ticks(1);
    rd(4'd1, 8'h59, "R4 second elapsed");

    // R5 BCD carry within the day
    set_time(8'h59, 8'h59, 8'h09, 8'h02, 8'h15, 8'h07, 8'h23, 8'h20);
    ticks(SECOND);
    rd(4'd1, 8'h00, "R5 seconds wrap");
    rd(4'd2, 8'h00, "R5 minutes wrap");
    rd(4'd3, 8'h10, "R5 hours BCD carry");
    rd(4'd5, 8'h15, "R5 date untouched");

    // R8 century, R6 weekday 7 to 1, R7 December end
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h20);
    ticks(SECOND);
    rd(4'd3, 8'h00, "R5 hours wrap");
    rd(4'd4, 8'h01, "R6 weekday wrap");
    rd(4'd5, 8'h01, "R7 date after Dec 31");
    rd(4'd6, 8'h01, "R7 month wrap");
    rd(4'd7, 8'h00, "R8 year wrap");
    rd(4'd8, 8'h21, "R8 century step");

    // R7 February rules
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20);
    ticks(SECOND);
    rd(4'd5, 8'h29, "R7 leap year 24 Feb 29");
    rd(4'd4, 8'h04, "R6 weekday step");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24, 8'h20);
    ticks(SECOND);
    rd(4'd5, 8'h01, "R7 leap Feb 29 end");
    rd(4'd6, 8'h03, "R7 leap March");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23, 8'h20);
    ticks(SECOND);
    rd(4'd5, 8'h01, "R7 common year 23");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00, 8'h20);
    ticks(SECOND);
    rd(4'd5, 8'h29, "R7 year 00 leap");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h10, 8'h20);
    ticks(SECOND);
    rd(4'd5, 8'h01, "R7 year 10 common");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h12, 8'h20);
    ticks(SECOND);
    rd(4'd5, 8'h29, "R7 year 12 leap");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23, 8'h20);
    ticks(SECOND);
    rd(4'd5, 8'h01, "R7 April end");
    rd(4'd6, 8'h05, "R7 May");

    // R12 divider test output after a load
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20);
    #1;
    check(sq512 == 1'b0, "R12 low after load", sq512, 0);
    ticks(2);
    #1;
    check(sq512 == 1'b1, "R12 high after two pulses", sq512, 1);
    ticks(2);
    #1;
    check(sq512 == 1'b0, "R12 low after four pulses", sq512, 0);

    // R9 freeze snapshot, time keeps running
    set_time(8'h10, 8'h30, 8'h12, 8'h01, 8'h05, 8'h06, 8'h30, 8'h20);
    wr(4'd0, 8'h01);
    rd(4'd0, 8'h01, "R2 control readback");
    ticks(SECOND);
    rd(4'd1, 8'h10, "R9 frozen seconds");
    wr(4'd0, 8'h00);
    rd(4'd1, 8'h11, "R9 live after thaw");

    // R2 ignored slot, R1 write needs chip enable
    wr(4'd10, 8'h55);
    rd(4'd10, 8'h00, "R2 slot write ignored");
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b0; addr = {{(AW-4){1'b1}}, 4'd1}; wdata = 8'h44;
    @(negedge clk);
    we_n = 1'b1;
    rd(4'd1, 8'h11, "R1 write without enable ignored");

    // R11 stop holds time, loads still happen
    set_time(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20);
    wr(4'd0, 8'h02);
    ticks(SECOND);
    rd(4'd1, 8'h05, "R11 stopped");
    wr(4'd1, 8'h30);
    ticks(1);
    wr(4'd0, 8'h00);
    ticks(SECOND);
    rd(4'd1, 8'h31, "R11 load while stopped");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule